// File: doc/BRIEF.md
# Register Window Frame Cache

This block keeps the local registers of the most recent procedure activations on chip. Each activation owns a frame of sixteen 32-bit words. The frame of the running procedure is the only one visible through the block's read and write ports. A call request opens a new frame. A return request discards the current frame and makes the caller's frame current again, with its contents as they were left.

Frames sit in a small ring of slots. A head index marks the current frame and a count records how many frames are resident, from one up to the number of slots. A call made with every slot occupied first moves the oldest resident frame, one word at a time, to a stack in memory over a request/acknowledge port. It then reuses that slot. A return whose caller is no longer resident reads that frame back from the stack before it completes. A frame pointer register tracks the top of the memory stack. A busy output covers every memory transfer. Global registers are not part of this block and are never saved or swapped.

Top module: `regwin_cache`

## Requirements
- R1: After reset, `busy`, `call_done`, `ret_done`, `underflow_err` and `mem_req` are low, `depth` is 0 and `frame_ptr` equals the parameter `FP_BASE`.
- R2: While `busy` is low, `wr_en` stores `wr_data` into word `wr_idx` (0 to 15) of the current frame at the clock edge. `rd_data` shows word `rd_idx` of the current frame without a clock delay.
- R3: A call accepted while fewer than four frames are resident makes no memory access. `call_done` is high for exactly the one cycle after acceptance, `busy` stays low and `depth` rises by one.
- R4: A call accepted while four frames are resident sets `busy`. It writes the 16 words of the oldest resident frame to memory (`mem_we` high), word k to address `frame_ptr + 4*k`, in ascending k. It then raises `frame_ptr` by 64, raises `depth` by one and pulses `call_done`. `frame_ptr` only ever changes in steps of 64.
- R5: A return accepted with `depth` above 0 and at least two resident frames makes no memory access. `ret_done` is high for the one cycle after acceptance, `depth` falls by one, and the caller frame's words read back as they were last written.
- R6: A return accepted with `depth` above 0 and one resident frame lowers `frame_ptr` by 64. It then reads 16 words (`mem_we` low) from `frame_ptr + 4*k` in ascending k into the caller's frame, and then pulses `ret_done` and lowers `depth` by one.
- R7: `busy` is high from the cycle after a spilling call or a filling return is accepted until the cycle its done pulse appears. While `busy` is high, call requests, return requests and writes are ignored, and no done or error pulse is raised.
- R8: A return request at `depth` 0 raises `underflow_err` for exactly one cycle. `depth`, `frame_ptr` and the current frame's contents are left unchanged.
- R9: Once `mem_req` is raised, it stays high with `mem_addr`, `mem_we` and `mem_wdata` unchanged until a cycle with `mem_ack` high.
- R10: When a call and a return are requested in the same idle cycle, only the call is carried out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| call_req | input | 1 | Request to open a new frame |
| ret_req | input | 1 | Request to drop the current frame and resume the caller |
| wr_en | input | 1 | Write enable for the current frame |
| wr_idx | input | 4 | Word index of the write |
| wr_data | input | 32 | Write data |
| rd_idx | input | 4 | Word index of the read |
| rd_data | output | 32 | Word `rd_idx` of the current frame |
| busy | output | 1 | Spill or fill in progress |
| call_done | output | 1 | One-cycle pulse: call finished |
| ret_done | output | 1 | One-cycle pulse: return finished |
| underflow_err | output | 1 | One-cycle pulse: return refused at depth 0 |
| depth | output | 16 | Number of calls outstanding |
| frame_ptr | output | 32 | Byte address of the top of the memory frame stack |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | 1 for a spill write, 0 for a fill read |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Spill data |
| mem_ack | input | 1 | Memory accepts or returns the word this cycle |
| mem_rdata | input | 32 | Fill data, valid with `mem_ack` |

## Verification
The bench uses the default build: four slots, sixteen 32-bit words per frame and a 16-bit depth counter. With only four slots, a call nesting of five already forces a spill. A random walk of calls and returns to depths near forty keeps the ring wrapping and drives several consecutive fills back down. The memory model stretches acknowledges at random, so held requests and requests, writes or returns arriving while `busy` is high are both exercised.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

    typedef enum logic [1:0] {
        RW_IDLE  = 2'd0,
        RW_SPILL = 2'd1,
        RW_FILL  = 2'd2
    } rw_state_e;

endpackage

// File: rtl/regwin_store.sv
module regwin_store #(
    parameter int DATA_W = 32,
    parameter int REGS   = 16,
    parameter int SLOTS  = 4,
    localparam int IDX_W  = $clog2(REGS),
    localparam int SLOT_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [SLOT_W-1:0] w_slot,
    input  logic [IDX_W-1:0]  w_idx,
    input  logic [DATA_W-1:0] w_data,
    input  logic [SLOT_W-1:0] a_slot,
    input  logic [IDX_W-1:0]  a_idx,
    output logic [DATA_W-1:0] a_data,
    input  logic [SLOT_W-1:0] b_slot,
    input  logic [IDX_W-1:0]  b_idx,
    output logic [DATA_W-1:0] b_data
);

    logic [DATA_W-1:0] cells_q [SLOTS][REGS];

    always_ff @(posedge clk) begin
        if (we) begin
            cells_q[w_slot][w_idx] <= w_data;
        end
    end

    always_comb begin
        a_data = cells_q[a_slot][a_idx];
        b_data = cells_q[b_slot][b_idx];
    end

endmodule

// File: rtl/regwin_ctrl.sv
module regwin_ctrl
    import regwin_pkg::*;
#(
    parameter int          DATA_W  = 32,
    parameter int          REGS    = 16,
    parameter int          SLOTS   = 4,
    parameter int          ADDR_W  = 32,
    parameter int          DEPTH_W = 16,
    parameter logic [31:0] FP_BASE = 32'h0000_1000,
    localparam int IDX_W  = $clog2(REGS),
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int CNT_W  = $clog2(SLOTS + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               call_req,
    input  logic               ret_req,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               mem_ack,
    input  logic [DATA_W-1:0]  mem_rdata,
    output logic [SLOT_W-1:0]  head,
    output logic [SLOT_W-1:0]  spill_slot,
    output logic [IDX_W-1:0]   word_idx,
    output logic               st_we,
    output logic [SLOT_W-1:0]  st_wslot,
    output logic [IDX_W-1:0]   st_widx,
    output logic [DATA_W-1:0]  st_wdata,
    output logic               busy,
    output logic               call_done,
    output logic               ret_done,
    output logic               underflow_err,
    output logic [DEPTH_W-1:0] depth,
    output logic [ADDR_W-1:0]  frame_ptr,
    output logic               mem_req,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  mem_addr
);

    localparam logic [ADDR_W-1:0] WORD_BYTES  = ADDR_W'(DATA_W / 8);
    localparam logic [ADDR_W-1:0] FRAME_BYTES = ADDR_W'(REGS * (DATA_W / 8));
    localparam logic [IDX_W-1:0]  LAST_WORD   = IDX_W'(REGS - 1);
    localparam logic [CNT_W-1:0]  FULL_CNT    = CNT_W'(SLOTS);

    typedef struct packed {
        rw_state_e          st;
        logic [SLOT_W-1:0]  head;
        logic [CNT_W-1:0]   cnt;
        logic [DEPTH_W-1:0] depth;
        logic [ADDR_W-1:0]  fp;
        logic [IDX_W-1:0]   word;
        logic               call_done;
        logic               ret_done;
        logic               uflow;
    } ctrl_s;

    ctrl_s ctl_d, ctl_q;

    always_comb begin
        ctl_d           = ctl_q;
        ctl_d.call_done = 1'b0;
        ctl_d.ret_done  = 1'b0;
        ctl_d.uflow     = 1'b0;
        unique case (ctl_q.st)
            RW_IDLE: begin
                if (call_req) begin
                    if (ctl_q.cnt < FULL_CNT) begin
                        ctl_d.head      = ctl_q.head + 1'b1;
                        ctl_d.cnt       = ctl_q.cnt + 1'b1;
                        ctl_d.depth     = ctl_q.depth + 1'b1;
                        ctl_d.call_done = 1'b1;
                    end else begin
                        ctl_d.st   = RW_SPILL;
                        ctl_d.word = '0;
                    end
                end else if (ret_req) begin
                    if (ctl_q.depth == '0) begin
                        ctl_d.uflow = 1'b1;
                    end else if (ctl_q.cnt > CNT_W'(1)) begin
                        ctl_d.head     = ctl_q.head - 1'b1;
                        ctl_d.cnt      = ctl_q.cnt - 1'b1;
                        ctl_d.depth    = ctl_q.depth - 1'b1;
                        ctl_d.ret_done = 1'b1;
                    end else begin
                        ctl_d.st   = RW_FILL;
                        ctl_d.word = '0;
                        ctl_d.fp   = ctl_q.fp - FRAME_BYTES;
                    end
                end
            end
            RW_SPILL: begin
                if (mem_ack) begin
                    if (ctl_q.word == LAST_WORD) begin
                        ctl_d.st        = RW_IDLE;
                        ctl_d.fp        = ctl_q.fp + FRAME_BYTES;
                        ctl_d.head      = ctl_q.head + 1'b1;
                        ctl_d.depth     = ctl_q.depth + 1'b1;
                        ctl_d.call_done = 1'b1;
                    end else begin
                        ctl_d.word = ctl_q.word + 1'b1;
                    end
                end
            end
            RW_FILL: begin
                if (mem_ack) begin
                    if (ctl_q.word == LAST_WORD) begin
                        ctl_d.st       = RW_IDLE;
                        ctl_d.head     = ctl_q.head - 1'b1;
                        ctl_d.depth    = ctl_q.depth - 1'b1;
                        ctl_d.ret_done = 1'b1;
                    end else begin
                        ctl_d.word = ctl_q.word + 1'b1;
                    end
                end
            end
            default: ctl_d.st = RW_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q           <= '0;
            ctl_q.st        <= RW_IDLE;
            ctl_q.cnt       <= CNT_W'(1);
            ctl_q.fp        <= ADDR_W'(FP_BASE);
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        head          = ctl_q.head;
        spill_slot    = ctl_q.head + 1'b1;
        word_idx      = ctl_q.word;
        busy          = (ctl_q.st != RW_IDLE);
        call_done     = ctl_q.call_done;
        ret_done      = ctl_q.ret_done;
        underflow_err = ctl_q.uflow;
        depth         = ctl_q.depth;
        frame_ptr     = ctl_q.fp;
        mem_req       = (ctl_q.st == RW_SPILL) || (ctl_q.st == RW_FILL);
        mem_we        = (ctl_q.st == RW_SPILL);
        mem_addr      = ctl_q.fp + (ADDR_W'(ctl_q.word) * WORD_BYTES);
        if (ctl_q.st == RW_FILL) begin
            st_we    = mem_ack;
            st_wslot = ctl_q.head - 1'b1;
            st_widx  = ctl_q.word;
            st_wdata = mem_rdata;
        end else begin
            st_we    = wr_en && (ctl_q.st == RW_IDLE);
            st_wslot = ctl_q.head;
            st_widx  = wr_idx;
            st_wdata = wr_data;
        end
    end

endmodule

// File: rtl/regwin_cache.sv
module regwin_cache #(
    parameter int          DATA_W  = 32,
    parameter int          REGS    = 16,
    parameter int          SLOTS   = 4,
    parameter int          ADDR_W  = 32,
    parameter int          DEPTH_W = 16,
    parameter logic [31:0] FP_BASE = 32'h0000_1000,
    localparam int IDX_W  = $clog2(REGS),
    localparam int SLOT_W = $clog2(SLOTS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               call_req,
    input  logic               ret_req,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [DATA_W-1:0]  rd_data,
    output logic               busy,
    output logic               call_done,
    output logic               ret_done,
    output logic               underflow_err,
    output logic [DEPTH_W-1:0] depth,
    output logic [ADDR_W-1:0]  frame_ptr,
    output logic               mem_req,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [DATA_W-1:0]  mem_wdata,
    input  logic               mem_ack,
    input  logic [DATA_W-1:0]  mem_rdata
);

    logic [SLOT_W-1:0] head;
    logic [SLOT_W-1:0] spill_slot;
    logic [IDX_W-1:0]  word_idx;
    logic              st_we;
    logic [SLOT_W-1:0] st_wslot;
    logic [IDX_W-1:0]  st_widx;
    logic [DATA_W-1:0] st_wdata;

    regwin_ctrl #(
        .DATA_W (DATA_W),
        .REGS   (REGS),
        .SLOTS  (SLOTS),
        .ADDR_W (ADDR_W),
        .DEPTH_W(DEPTH_W),
        .FP_BASE(FP_BASE)
    ) ctrl_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .call_req     (call_req),
        .ret_req      (ret_req),
        .wr_en        (wr_en),
        .wr_idx       (wr_idx),
        .wr_data      (wr_data),
        .mem_ack      (mem_ack),
        .mem_rdata    (mem_rdata),
        .head         (head),
        .spill_slot   (spill_slot),
        .word_idx     (word_idx),
        .st_we        (st_we),
        .st_wslot     (st_wslot),
        .st_widx      (st_widx),
        .st_wdata     (st_wdata),
        .busy         (busy),
        .call_done    (call_done),
        .ret_done     (ret_done),
        .underflow_err(underflow_err),
        .depth        (depth),
        .frame_ptr    (frame_ptr),
        .mem_req      (mem_req),
        .mem_we       (mem_we),
        .mem_addr     (mem_addr)
    );

    regwin_store #(
        .DATA_W(DATA_W),
        .REGS  (REGS),
        .SLOTS (SLOTS)
    ) store_i (
        .clk   (clk),
        .we    (st_we),
        .w_slot(st_wslot),
        .w_idx (st_widx),
        .w_data(st_wdata),
        .a_slot(head),
        .a_idx (rd_idx),
        .a_data(rd_data),
        .b_slot(spill_slot),
        .b_idx (word_idx),
        .b_data(mem_wdata)
    );

endmodule

// File: rtl/regwin_cache_chk.sv
module regwin_cache_chk #(
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 32,
    parameter int DEPTH_W = 16,
    parameter int REGS    = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               busy,
    input logic               call_done,
    input logic               ret_done,
    input logic               underflow_err,
    input logic [DEPTH_W-1:0] depth,
    input logic [ADDR_W-1:0]  frame_ptr,
    input logic               mem_req,
    input logic               mem_we,
    input logic [ADDR_W-1:0]  mem_addr,
    input logic [DATA_W-1:0]  mem_wdata,
    input logic               mem_ack
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(REGS * (DATA_W / 8));

    a_r9_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    a_r7_quiet_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!call_done && !ret_done && !underflow_err));

    a_r7_busy_ends_in_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (call_done || ret_done));

    a_r8_uflow_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
        underflow_err |-> ($stable(depth) && $stable(frame_ptr) && depth == '0 && !busy));

    a_r3_call_depth_up: assert property (@(posedge clk) disable iff (!rst_n)
        call_done |-> (depth == $past(depth) + 1'b1));

    a_r5_ret_depth_down: assert property (@(posedge clk) disable iff (!rst_n)
        ret_done |-> (depth == $past(depth) - 1'b1));

    a_r4_fp_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_ptr != $past(frame_ptr)) |-> (frame_ptr == $past(frame_ptr) + STEP || frame_ptr == $past(frame_ptr) - STEP));

    a_r3_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({call_done, ret_done, underflow_err}));

endmodule

bind regwin_cache regwin_cache_chk #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .DEPTH_W(DEPTH_W),
    .REGS   (REGS)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (busy),
    .call_done    (call_done),
    .ret_done     (ret_done),
    .underflow_err(underflow_err),
    .depth        (depth),
    .frame_ptr    (frame_ptr),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .mem_ack      (mem_ack)
);

// File: tb/regwin_cache_tb.sv
module regwin_cache_tb_top;

    localparam logic [31:0] BASE = 32'h0000_1000;
    localparam int NSLOT = 4;
    localparam int MAXD  = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        call_req = 1'b0, ret_req = 1'b0, wr_en = 1'b0;
    logic [3:0]  wr_idx = '0, rd_idx = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        busy, call_done, ret_done, underflow_err;
    logic [15:0] depth;
    logic [31:0] frame_ptr;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    always #4 clk = ~clk;

    regwin_cache #(.FP_BASE(BASE)) dut_i (
        .clk(clk), .rst_n(rst_n), .call_req(call_req), .ret_req(ret_req),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .rd_idx(rd_idx),
        .rd_data(rd_data), .busy(busy), .call_done(call_done), .ret_done(ret_done),
        .underflow_err(underflow_err), .depth(depth), .frame_ptr(frame_ptr),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    // behavioural memory with random acknowledge delay
    logic [31:0] bmem [logic [31:0]];
    int wr_cnt = 0, rd_cnt = 0;
    always @(negedge clk) begin
        if (mem_req && ($urandom % 3 != 0)) begin
            mem_ack = 1'b1;
            if (mem_we) begin
                bmem[mem_addr] = mem_wdata;
                wr_cnt++;
            end else begin
                mem_rdata = bmem.exists(mem_addr) ? bmem[mem_addr] : 32'h0;
                rd_cnt++;
            end
        end else begin
            mem_ack = 1'b0;
        end
    end

    int n_chk = 0, n_fail = 0;
    logic [31:0] mframes [MAXD][16];
    int mdepth = 0, mres = 1;

    function automatic logic [31:0] exp_fp(int d, int r);
        return BASE + 32'(64 * (d + 1 - r));
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        chk(act === exp, tag, act, exp);
    endtask

    task automatic wr(input int idx, input logic [31:0] v);
        wr_en = 1'b1; wr_idx = 4'(idx); wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
        mframes[mdepth][idx] = v;
    endtask

    task automatic rd_chk(input int idx, input string tag);
        rd_idx = 4'(idx);
        #1;
        chk_eq(tag, rd_data, mframes[mdepth][idx]);
    endtask

    task automatic fill_frame();
        for (int k = 0; k < 16; k++) wr(k, $urandom);
    endtask

    task automatic check_frame(input string tag);
        for (int k = 0; k < 16; k++) rd_chk(k, tag);
    endtask

    task automatic chk_state(input string tag);
        chk_eq({tag, " depth"}, 32'(depth), 32'(mdepth));
        chk_eq({tag, " frame_ptr"}, frame_ptr, exp_fp(mdepth, mres));
    endtask

    task automatic wait_done(input bit is_call, input string tag);
        int g = 0;
        while (!(is_call ? call_done : ret_done) && g < 400) begin
            @(negedge clk);
            g++;
        end
        chk(g < 400, {tag, " done pulse"}, 32'(g), 32'd400);
    endtask

    task automatic do_call(input bit poke, input bit both);
        int wc0 = wr_cnt;
        bit spill = (mres == NSLOT);
        logic [31:0] fp0 = frame_ptr;
        call_req = 1'b1; ret_req = both;
        @(negedge clk);
        call_req = 1'b0; ret_req = 1'b0;
        if (!spill) begin
            chk_eq("R3 call_done next cycle", 32'(call_done), 32'd1);
            chk_eq("R3 busy stays low", 32'(busy), 32'd0);
            if (both) chk_eq("R10 call wins, no ret_done", 32'(ret_done), 32'd0);
            mres++;
        end else begin
            chk_eq("R7 busy during spill", 32'(busy), 32'd1);
            if (poke) begin
                call_req = 1'b1; ret_req = 1'b1; wr_en = 1'b1;
                wr_idx = 4'd3; wr_data = 32'hDEAD_BEEF;
                @(negedge clk);
                call_req = 1'b0; ret_req = 1'b0; wr_en = 1'b0;
            end
            wait_done(1'b1, "R4");
            chk_eq("R4 spill word count", 32'(wr_cnt - wc0), 32'd16);
            for (int k = 0; k < 16; k++)
                chk_eq("R4 spilled word", bmem.exists(fp0 + 32'(4 * k)) ? bmem[fp0 + 32'(4 * k)] : 32'hX,
                       mframes[mdepth - 3][k]);
        end
        mdepth++;
        if (!spill) chk_eq("R3 no memory traffic", 32'(wr_cnt - wc0), 32'd0);
        chk_state(spill ? "R4" : "R3");
        @(negedge clk);
        chk_eq(both ? "R10 busy after" : "R7 busy after call", 32'(busy), 32'd0);
        fill_frame();
    endtask

    task automatic do_ret();
        int rc0 = rd_cnt;
        bit fill = (mres == 1);
        logic [31:0] fp0 = frame_ptr;
        if (mdepth == 0) begin
            ret_req = 1'b1;
            @(negedge clk);
            ret_req = 1'b0;
            chk_eq("R8 underflow_err", 32'(underflow_err), 32'd1);
            chk_eq("R8 frame_ptr kept", frame_ptr, fp0);
            chk_eq("R8 depth kept", 32'(depth), 32'd0);
            chk_eq("R8 no ret_done", 32'(ret_done), 32'd0);
            @(negedge clk);
            chk_eq("R8 one-cycle pulse", 32'(underflow_err), 32'd0);
            check_frame("R8 frame kept");
            return;
        end
        ret_req = 1'b1;
        @(negedge clk);
        ret_req = 1'b0;
        if (!fill) begin
            chk_eq("R5 ret_done next cycle", 32'(ret_done), 32'd1);
            chk_eq("R5 busy stays low", 32'(busy), 32'd0);
            mres--;
        end else begin
            chk_eq("R7 busy during fill", 32'(busy), 32'd1);
            chk_eq("R6 frame_ptr lowered first", frame_ptr, fp0 - 32'd64);
            wait_done(1'b0, "R6");
            chk_eq("R6 fill word count", 32'(rd_cnt - rc0), 32'd16);
        end
        mdepth--;
        if (!fill) chk_eq("R5 no memory traffic", 32'(rd_cnt - rc0), 32'd0);
        chk_state(fill ? "R6" : "R5");
        @(negedge clk);
        check_frame(fill ? "R6 filled frame" : "R5 caller frame");
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd7421));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk_eq("R1 busy", 32'(busy), 32'd0);
        chk_eq("R1 call_done", 32'(call_done), 32'd0);
        chk_eq("R1 ret_done", 32'(ret_done), 32'd0);
        chk_eq("R1 underflow_err", 32'(underflow_err), 32'd0);
        chk_eq("R1 mem_req", 32'(mem_req), 32'd0);
        chk_eq("R1 depth", 32'(depth), 32'd0);
        chk_eq("R1 frame_ptr", frame_ptr, BASE);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 write and combinational read
        fill_frame();
        check_frame("R2 root frame");
        wr(5, 32'h1234_5678);
        rd_chk(5, "R2 overwrite");

        // R8 underflow at depth 0
        do_ret();

        // R3, then R4 spills from depth 3 upward
        for (int i = 0; i < 6; i++) do_call(1'b0, 1'b0);
        // R7 requests and writes during a spill are ignored
        do_call(1'b1, 1'b0);
        do_ret();   // back to the poked frame, word 3 must be intact
        // R5 and R6 all the way down
        while (mdepth > 0) do_ret();
        do_ret();   // R8 again after unwinding
        // R10 simultaneous requests
        do_call(1'b0, 1'b1);
        do_ret();

        // random walk
        for (int it = 0; it < 400; it++) begin
            int r = int'($urandom % 10);
            if (r < 4 && mdepth < 40) do_call(1'b0, 1'b0);
            else if (r < 7) do_ret();
            else if (r == 7) wr(int'($urandom % 16), $urandom);
            else rd_chk(int'($urandom % 16), "R2 random read");
        end
        while (mdepth > 0) do_ret();
        check_frame("R6 root frame after walk");

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule